// File: doc/BRIEF.md
# UART Receive Buffer with Character Timeout

This block sits between a serial deserialiser and the register interface of a 16550-style UART. Each byte the deserialiser delivers, and each detected break, is stored either in a 16-entry first-in first-out queue (queue mode) or in a single holding register (single-byte mode). The block keeps the receive status that the interrupt unit needs: data ready, overrun, break and character-timeout pending. It also exports the queue occupancy and the programmed trigger level, so the interrupt unit can compare the two.

Configuration arrives as a one-cycle strobe carrying the FIFO control byte: bit 0 selects queue mode, bit 1 flushes the receive side, and bits 7:6 pick the trigger level. A frame-format nibble and a bit period in clock cycles set the length of one character. The timeout fires when data has sat untouched for four character times.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset the block is in single-byte mode, `statusVec` and `fifoCount` are 0, `trigLevel` is 1 and `rdData` is 0x00.
- R2: On a config write, bits 7:6 set `trigLevel`: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. A write that keeps bit 0 unchanged and has bit 1 clear leaves the stored bytes in place.
- R3: In queue mode, bytes are read back in arrival order. `statusVec[0]` (data ready) is set exactly when `fifoCount` is non-zero. A byte that arrives while 16 bytes are held is dropped, the held bytes are kept, and `statusVec[1]` (overrun) is set.
- R4: A break event stores a 0x00 byte and sets `statusVec[2]` (break) and data ready. If a byte arrives in the same cycle as a break, the break wins. Break clears when a read leaves the queue empty.
- R5: In queue mode, each received byte, and each read that leaves data behind, restarts a timer of 4 × frameBits × bitPeriod cycles. frameBits is 1 start bit, plus 5 + `frameCfg[1:0]` data bits, plus 1 parity bit if `frameCfg[3]` is set, plus 2 stop bits if `frameCfg[2]` is set (1 otherwise). When the timer expires with data held, `statusVec[3]` (timeout pending) is set exactly that many cycles after the restarting edge. When it expires with the queue empty, nothing is set.
- R6: Any read in queue mode clears timeout pending. A read that leaves data behind restarts the timer.
- R7: A config write with bit 1 set empties the queue and clears data ready, break, timeout pending and the running timer. A byte arriving in that cycle is discarded.
- R8: A config write that changes bit 0 flushes exactly as R7 does, whatever the value of bit 1.
- R9: In single-byte mode, a new byte overwrites the holding register, and it sets overrun if data ready was set and no read happens that cycle. A read returns the holding register and clears data ready.
- R10: A bit period of 0 is replaced by the fixed period `ZERO_DIV_PERIOD`.
- R11: When a read and an arriving byte fall in the same cycle in queue mode, the read returns the oldest byte and the new byte is stored. This holds even with 16 bytes held, and in that case no overrun is raised. Reading an empty queue returns 0x00.
- R12: A `statusAck` pulse clears overrun and break. If an overrun or a break arrives in the same cycle, setting wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxValid | input | 1 | One-cycle strobe: a received byte is on rxData |
| rxData | input | 8 | Received byte |
| rxBreak | input | 1 | One-cycle strobe: a break condition was detected |
| rdEn | input | 1 | Data read strobe; pops a byte in queue mode |
| rdData | output | 8 | Byte returned by a read in this cycle |
| statusAck | input | 1 | Status read strobe; clears overrun and break |
| cfgWr | input | 1 | FIFO control write strobe |
| cfgData | input | 8 | FIFO control byte: [0] queue mode, [1] flush, [7:6] trigger |
| frameCfg | input | 4 | Frame format: [1:0] data length − 5, [2] two stop bits, [3] parity |
| bitPeriod | input | 16 | Clock cycles per bit; 0 selects ZERO_DIV_PERIOD |
| statusVec | output | 4 | {timeout pending, break, overrun, data ready} |
| fifoCount | output | 5 | Number of bytes held in the queue |
| trigLevel | output | 5 | Programmed trigger level in bytes |

## Verification
The collision that matters most is a read and an arriving byte in the same cycle. It changes the outcome both when the queue is full (the byte must be accepted, not counted as an overrun) and when one byte is held (data ready must stay set). The bench fills the queue to 16 and then drives `rdEn` and `rxValid` in the same cycle. It expects the oldest byte on `rdData`, an unchanged count of 16 with overrun clear, and the new byte last when the queue is drained. A second collision also gets a check: a byte arriving in the same cycle as a break, where only the null byte may be stored.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  localparam int BYTE_W = 8;

  // Strobes from the control to the storage datapath, valid for one cycle
  typedef struct packed {
    logic              push;      // append wrByte to the queue
    logic              pop;       // drop the oldest entry
    logic              flush;     // empty the queue
    logic              holdLoad;  // load wrByte into the holding register
    logic [BYTE_W-1:0] wrByte;
  } rxqStrobe_t;
endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  rxqStrobe_t                   stb,
  input  logic                         fifoOn,
  output logic [$clog2(DEPTH):0]       count,
  output logic                         full,
  output logic [BYTE_W-1:0]            headByte
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = PTR_W + 1;

  logic [BYTE_W-1:0] entry [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] holdReg;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) entry[i] <= '0;
      else if (stb.push && wrPtr == PTR_W'(i)) entry[i] <= stb.wrByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (stb.push) wrPtr <= bump(wrPtr);
      if (stb.pop)  rdPtr <= bump(rdPtr);
      cnt <= cnt + CNT_W'(stb.push) - CNT_W'(stb.pop);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             holdReg <= '0;
    else if (stb.holdLoad) holdReg <= stb.wrByte;
  end

  assign count    = cnt;
  assign full     = (cnt == CNT_W'(DEPTH));
  assign headByte = !fifoOn ? holdReg : ((cnt == '0) ? '0 : entry[rdPtr]);
endmodule

// File: rtl/rxq_control.sv
module rxq_control
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH           = 16,
  parameter int DIV_W           = 16,
  parameter int ZERO_DIV_PERIOD = 33
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rxValid,
  input  logic [BYTE_W-1:0]      rxData,
  input  logic                   rxBreak,
  input  logic                   rdEn,
  input  logic                   statusAck,
  input  logic                   cfgWr,
  input  logic [7:0]             cfgData,
  input  logic [3:0]             frameCfg,
  input  logic [DIV_W-1:0]       bitPeriod,
  input  logic [$clog2(DEPTH):0] count,
  input  logic                   full,
  output rxqStrobe_t             stb,
  output logic                   fifoOn,
  output logic [3:0]             statusVec,
  output logic [$clog2(DEPTH):0] trigLevel
);
  localparam int CNT_W = $clog2(DEPTH) + 1;
  localparam int TMO_W = DIV_W + 6;

  logic             fifoOnQ, drQ, brkQ, ovrQ, tmoPendQ, tmoRunQ;
  logic [1:0]       trigSelQ;
  logic [TMO_W-1:0] tmoCntQ;

  logic flush, incoming, pop, push, ovrSet, readEmpties, brkClr, restart, expire;
  logic [CNT_W-1:0] countAfter;
  logic [3:0]       frameBits;
  logic [DIV_W-1:0] periodEff;
  logic [TMO_W-1:0] quadChar;

  always_comb begin
    flush      = cfgWr && (cfgData[1] || (cfgData[0] != fifoOnQ));
    incoming   = (rxValid || rxBreak) && !flush;
    pop        = rdEn && !flush && fifoOnQ && (count != '0);
    push       = fifoOnQ && incoming && (!full || pop);
    ovrSet     = incoming && (fifoOnQ ? (full && !pop) : (drQ && !rdEn));
    countAfter = count + CNT_W'(push) - CNT_W'(pop);
    readEmpties = rdEn && !flush && (fifoOnQ ? (countAfter == '0) : !incoming);
    brkClr     = statusAck || (rdEn && !flush && (!fifoOnQ || countAfter == '0));
    restart    = fifoOnQ && !flush && (incoming || (pop && countAfter != '0));
    expire     = tmoRunQ && (tmoCntQ == '0) && !restart;

    frameBits = 4'd7 + {2'b00, frameCfg[1:0]} + {3'b000, frameCfg[3]} + {3'b000, frameCfg[2]};
    periodEff = (bitPeriod == '0) ? DIV_W'(ZERO_DIV_PERIOD) : bitPeriod;
    quadChar  = TMO_W'({frameBits, 2'b00}) * TMO_W'(periodEff);

    stb.push     = push;
    stb.pop      = pop;
    stb.flush    = flush;
    stb.holdLoad = !fifoOnQ && incoming;
    stb.wrByte   = rxBreak ? '0 : rxData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoOnQ  <= 1'b0;
      trigSelQ <= 2'b00;
    end else if (cfgWr) begin
      fifoOnQ  <= cfgData[0];
      trigSelQ <= cfgData[7:6];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drQ  <= 1'b0;
      brkQ <= 1'b0;
      ovrQ <= 1'b0;
    end else begin
      if (flush)            drQ <= 1'b0;
      else if (incoming)    drQ <= 1'b1;
      else if (readEmpties) drQ <= 1'b0;

      if (flush)                   brkQ <= 1'b0;
      else if (rxBreak)            brkQ <= 1'b1;
      else if (brkClr)             brkQ <= 1'b0;

      if (ovrSet)         ovrQ <= 1'b1;
      else if (statusAck) ovrQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmoRunQ  <= 1'b0;
      tmoCntQ  <= '0;
      tmoPendQ <= 1'b0;
    end else begin
      if (flush) begin
        tmoRunQ <= 1'b0;
      end else if (restart) begin
        tmoRunQ <= 1'b1;
        tmoCntQ <= quadChar - 1'b1;
      end else if (tmoRunQ) begin
        if (tmoCntQ == '0) tmoRunQ <= 1'b0;
        else               tmoCntQ <= tmoCntQ - 1'b1;
      end

      if (flush)                    tmoPendQ <= 1'b0;
      else if (rdEn && fifoOnQ)     tmoPendQ <= 1'b0;
      else if (expire && count != '0) tmoPendQ <= 1'b1;
    end
  end

  always_comb begin
    case (trigSelQ)
      2'b00:   trigLevel = CNT_W'(1);
      2'b01:   trigLevel = CNT_W'(4);
      2'b10:   trigLevel = CNT_W'(8);
      default: trigLevel = CNT_W'(14);
    endcase
  end

  assign fifoOn    = fifoOnQ;
  assign statusVec = {tmoPendQ, brkQ, ovrQ, drQ};
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxq_pkg::*;
#(
  parameter int DEPTH           = 16,
  parameter int DIV_W           = 16,
  parameter int ZERO_DIV_PERIOD = 33
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   rxValid,
  input  logic [7:0]             rxData,
  input  logic                   rxBreak,
  input  logic                   rdEn,
  output logic [7:0]             rdData,
  input  logic                   statusAck,
  input  logic                   cfgWr,
  input  logic [7:0]             cfgData,
  input  logic [3:0]             frameCfg,
  input  logic [DIV_W-1:0]       bitPeriod,
  output logic [3:0]             statusVec,
  output logic [$clog2(DEPTH):0] fifoCount,
  output logic [$clog2(DEPTH):0] trigLevel
);
  rxqStrobe_t stb;
  logic       fifoOn;
  logic       full;

  rxq_control #(
    .DEPTH(DEPTH), .DIV_W(DIV_W), .ZERO_DIV_PERIOD(ZERO_DIV_PERIOD)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData),
    .rxBreak(rxBreak), .rdEn(rdEn), .statusAck(statusAck), .cfgWr(cfgWr),
    .cfgData(cfgData), .frameCfg(frameCfg), .bitPeriod(bitPeriod),
    .count(fifoCount), .full(full), .stb(stb), .fifoOn(fifoOn),
    .statusVec(statusVec), .trigLevel(trigLevel)
  );

  rxq_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .fifoOn(fifoOn),
    .count(fifoCount), .full(full), .headByte(rdData)
  );
endmodule

// File: rtl/uart_rx_buffer_checker.sv
module uart_rx_buffer_checker #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   rxValid,
  input logic                   rxBreak,
  input logic                   rdEn,
  input logic                   cfgWr,
  input logic [7:0]             cfgData,
  input logic [3:0]             statusVec,
  input logic [$clog2(DEPTH):0] fifoCount,
  input logic                   fifoOn
);
  localparam int CNT_W = $clog2(DEPTH) + 1;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  assert_ready_tracks_count_R3: assert property (@(posedge clk) disable iff (!rstN)
    fifoOn |-> (statusVec[0] == (fifoCount != '0)));

  assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (fifoOn && fifoCount == CNT_W'(DEPTH) && rxValid && !rdEn && !cfgWr)
      |=> (fifoCount == CNT_W'(DEPTH) && statusVec[1]));

  assert_break_marks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxBreak && !cfgWr) |=> (statusVec[2] && statusVec[0]));

  assert_read_clears_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && fifoOn && !cfgWr) |=> !statusVec[3]);

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgData[1]) |=> (fifoCount == '0 && !statusVec[0] && !statusVec[2] && !statusVec[3]));

  assert_single_mode_empty_R9: assert property (@(posedge clk) disable iff (!rstN)
    !fifoOn |-> (fifoCount == '0));
endmodule

bind uart_rx_buffer uart_rx_buffer_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxBreak(rxBreak), .rdEn(rdEn),
  .cfgWr(cfgWr), .cfgData(cfgData), .statusVec(statusVec),
  .fifoCount(fifoCount), .fifoOn(fifoOn)
);

// File: tb/uart_rx_buffer_bench.sv
module uart_rx_buffer_bench;
  localparam int ZDIV = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0, rxBreak = 1'b0, rdEn = 1'b0, statusAck = 1'b0, cfgWr = 1'b0;
  logic [7:0]  rxData = '0, cfgData = '0;
  logic [3:0]  frameCfg = '0;
  logic [15:0] bitPeriod = 16'd1;
  logic [7:0]  rdData;
  logic [3:0]  statusVec;
  logic [4:0]  fifoCount, trigLevel;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  uart_rx_buffer #(.DEPTH(16), .DIV_W(16), .ZERO_DIV_PERIOD(ZDIV)) u_uart_rx_buffer (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxBreak(rxBreak),
    .rdEn(rdEn), .rdData(rdData), .statusAck(statusAck), .cfgWr(cfgWr),
    .cfgData(cfgData), .frameCfg(frameCfg), .bitPeriod(bitPeriod),
    .statusVec(statusVec), .fifoCount(fifoCount), .trigLevel(trigLevel)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pushB(input logic [7:0] b);
    rxValid = 1'b1; rxData = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic sendBreak();
    rxBreak = 1'b1;
    @(negedge clk);
    rxBreak = 1'b0;
  endtask

  task automatic readB(output logic [7:0] b);
    rdEn = 1'b1;
    #1 b = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic writeCfg(input logic [7:0] v);
    cfgWr = 1'b1; cfgData = v;
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  task automatic ack();
    statusAck = 1'b1;
    @(negedge clk);
    statusAck = 1'b0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!statusVec[3] && n < 4000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 status", statusVec, 0);
    chk("R1 count", fifoCount, 0);
    chk("R1 trig", trigLevel, 1);
    chk("R1 rdData", rdData, 0);

    // R9 single-byte mode
    pushB(8'h41);
    chk("R9 ready", statusVec, 4'b0001);
    pushB(8'h42);
    chk("R9 overrun", statusVec, 4'b0011);
    readB(b);
    chk("R9 newest kept", b, 8'h42);
    chk("R9 ready cleared", statusVec[0], 0);
    chk("R9 count stays zero", fifoCount, 0);
    // R12 acknowledge clears overrun
    ack();
    chk("R12 overrun cleared", statusVec, 0);
    pushB(8'h55);

    // R8 enabling queue mode flushes (bit 1 clear)
    writeCfg(8'h01);
    chk("R8 ready cleared on enable", statusVec[0], 0);
    chk("R11 empty read zero", rdData, 0);

    // R2 trigger sweep keeps data
    pushB(8'h10);
    pushB(8'h11);
    for (int s = 0; s < 4; s++) begin
      writeCfg(8'(s << 6) | 8'h01);
      chk("R2 trig level", trigLevel, (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14);
      chk("R2 data kept", fifoCount, 2);
    end

    // R3 fill sweep with overrun drop
    for (int n2 = 0; n2 <= 17; n2++) begin
      writeCfg(8'h03);
      ack();
      for (int i = 0; i < n2; i++) pushB(8'((n2 * 16 + i * 5 + 1) & 8'hFF));
      chk("R3 count", fifoCount, (n2 > 16) ? 16 : n2);
      chk("R3 overrun", statusVec[1], (n2 > 16) ? 1 : 0);
      chk("R3 ready", statusVec[0], (n2 > 0) ? 1 : 0);
      for (int i = 0; i < ((n2 > 16) ? 16 : n2); i++) begin
        readB(b);
        chk("R3 order", b, (n2 * 16 + i * 5 + 1) & 8'hFF);
      end
      readB(b);
      chk("R11 empty read zero", b, 0);
      chk("R3 ready clear when empty", statusVec[0], 0);
    end

    // R4 break
    writeCfg(8'h03);
    ack();
    pushB(8'h77);
    rxValid = 1'b1; rxData = 8'h99;
    sendBreak();
    rxValid = 1'b0;
    chk("R4 break+ready", statusVec[2:0], 3'b101);
    chk("R4 one byte stored", fifoCount, 2);
    readB(b);
    chk("R4 first byte", b, 8'h77);
    chk("R4 break held while data left", statusVec[2], 1);
    readB(b);
    chk("R4 null byte", b, 0);
    chk("R4 break cleared on empty", statusVec[2:0], 3'b000);
    // R12 ack clears break
    sendBreak();
    ack();
    chk("R12 break cleared by ack", statusVec[2], 0);

    // R11 collision at full
    writeCfg(8'h03);
    ack();
    for (int i = 0; i < 16; i++) pushB(8'(i + 100));
    rxValid = 1'b1; rxData = 8'hEE;
    readB(b);
    rxValid = 1'b0;
    chk("R11 oldest returned", b, 100);
    chk("R11 count kept", fifoCount, 16);
    chk("R11 no overrun", statusVec[1], 0);
    for (int i = 0; i < 15; i++) begin
      readB(b);
      chk("R11 drain order", b, i + 101);
    end
    readB(b);
    chk("R11 new byte last", b, 8'hEE);
    // R11 collision with one held byte
    pushB(8'h21);
    rxValid = 1'b1; rxData = 8'h22;
    readB(b);
    rxValid = 1'b0;
    chk("R11 single read", b, 8'h21);
    chk("R11 ready stays", statusVec[0], 1);

    // R7 flush with incoming byte in same cycle
    rxValid = 1'b1; rxData = 8'h5A;
    writeCfg(8'h03);
    rxValid = 1'b0;
    chk("R7 flushed", fifoCount, 0);
    chk("R7 status cleared", statusVec & 4'b1101, 0);

    // R5 / R10 timeout length sweep
    for (int p = 0; p < 3; p++) begin
      for (int f = 0; f < 16; f++) begin
        int per, bits;
        per = (p == 0) ? 1 : (p == 1) ? 3 : 0;
        bitPeriod = 16'(per);
        frameCfg = 4'(f);
        bits = 7 + (f & 3) + ((f >> 3) & 1) + ((f >> 2) & 1);
        writeCfg(8'h03);
        pushB(8'h33);
        measure(n);
        chk(per == 0 ? "R10 zero-divisor timeout" : "R5 timeout length", n, 4 * bits * ((per == 0) ? ZDIV : per));
      end
    end

    // R5 no pending when queue empty at expiry
    bitPeriod = 16'd1; frameCfg = 4'd0;
    writeCfg(8'h03);
    pushB(8'h01);
    readB(b);
    repeat (40) @(negedge clk);
    chk("R5 no pending when empty", statusVec[3], 0);

    // R6 read clears pending and restarts
    writeCfg(8'h03);
    pushB(8'h01);
    pushB(8'h02);
    measure(n);
    chk("R6 first expiry", n, 28);
    readB(b);
    chk("R6 pending cleared by read", statusVec[3], 0);
    measure(n);
    chk("R6 restart after read", n, 28);

    // R8 disabling queue mode flushes without bit 1
    pushB(8'h09);
    writeCfg(8'h00);
    chk("R8 count cleared", fifoCount, 0);
    chk("R8 ready cleared", statusVec[0], 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule